// File: doc/BRIEF.md
# Dual-Half Registered Bus Transceiver

This block moves data between two 18-bit ports, A and B, in both directions. The bits form two 9-bit halves. Each half has its own set of controls for each direction: an output enable (active low), a latch enable and a direction clock. A join input makes the block behave as one 18-bit transceiver. In that mode the controls of half 0 govern both halves.

Each direction of each half has one storage element that serves as both a latch and a flip-flop.

- While the latch enable is high, the output follows the input in the same cycle.
- While the latch enable is low, the stored word holds.
- The exception is a rising edge of the direction clock. That clock is sampled on the system clock, and the edge is found by comparing it with a copy delayed by one cycle. On that edge the current input is stored.

Outputs come with a per-bit drive-enable vector that models the tri-state pins. A released bit reads as zero on the data output.

A test-mode input hands the pins over to boundary logic. In test mode the drive values and enables come from dedicated inputs, and the storage elements are frozen. A per-half contention flag reports when, in normal mode, both directions of that half are enabled to drive at once.

Top module: `ubt_xcvr`

## Requirements
- R1: In normal mode, when a half's effective latch enable for a direction is high, the data output of that half equals the source port's input in the same cycle.
- R2: In normal mode, with the latch enable low and no rising edge of the direction clock, the output of that half shows the word stored by the last sampling edge of the system clock. That word is the one captured while the latch enable was last high, or at the last direction-clock edge.
- R3: With the latch enable low, a direction clock that is high at a system clock edge after being low at the edge before stores the source input at that edge. The stored word appears on the output after that edge.
- R4: In normal mode, an output enable at 0 sets all 9 drive-enable bits of that half and direction to 1 and drives the data. An output enable at 1 clears the enable bits and forces the half's data output to 0.
- R5: B-to-A transfer obeys R1 to R4 with its own output enable, latch enable and clock, independently of A-to-B.
- R6: With the join input at 0, bits 8:0 use control index 0 and bits 17:9 use control index 1, and the two halves do not affect each other.
- R7: With the join input at 1, bits 17:9 use control index 0 in every respect, and the index-1 controls have no effect.
- R8: With the test-mode input at 1, a_out/a_oe equal tst_a_val/tst_a_en and b_out/b_oe equal tst_b_val/tst_b_en. The storage elements do not change, and the contention flags read 0.
- R9: Contention bit h is 1 exactly when test mode is 0 and both effective output enables of half h are 0.
- R10: An asynchronous active-low reset clears every stored word and the delayed clock copies to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | Hand pins to boundary logic |
| join18 | input | 1 | Operate as one 18-bit transceiver |
| a_in | input | 18 | A port input values |
| b_in | input | 18 | B port input values |
| ab_oe_n | input | 2 | A-to-B output enable per half, active low |
| ba_oe_n | input | 2 | B-to-A output enable per half, active low |
| ab_le | input | 2 | A-to-B latch enable per half |
| ba_le | input | 2 | B-to-A latch enable per half |
| ab_ck | input | 2 | A-to-B direction clock per half |
| ba_ck | input | 2 | B-to-A direction clock per half |
| tst_a_val | input | 18 | Boundary drive values for the A port |
| tst_a_en | input | 18 | Boundary drive enables for the A port |
| tst_b_val | input | 18 | Boundary drive values for the B port |
| tst_b_en | input | 18 | Boundary drive enables for the B port |
| a_out | output | 18 | A port drive values |
| a_oe | output | 18 | A port per-bit drive enables |
| b_out | output | 18 | B port drive values |
| b_oe | output | 18 | B port per-bit drive enables |
| contention | output | 2 | Both directions enabled in a half |

## Verification
The assertions check the following on every cycle:

- the same-cycle transparent path;
- the frozen word when neither the latch enable nor a clock edge allows an update;
- capture on a detected edge;
- the drive-enable mapping;
- the test-mode pin handover;
- the contention flag.

Only the bench's scenarios show the sequences over several cycles. These are the values held after the latch enable falls, the case where a clock held high stores nothing further, the isolation between halves and the override in joined mode, and the words that survive a test-mode interval.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

  localparam int unsigned DEF_HALF_W = 9;
  localparam int unsigned DEF_NHALF  = 2;

  // Effective control bit for a half: joined mode borrows index 0.
  function automatic logic ctl_pick(input logic join_mode, input logic own, input logic lead);
    return join_mode ? lead : own;
  endfunction

  // Storage update condition for one direction of one half.
  function automatic logic store_now(input logic frozen, input logic le, input logic rise);
    return !frozen && (le || rise);
  endfunction

  // Both directions enabled to drive in normal mode.
  function automatic logic clash(input logic tst, input logic oe_ab_n, input logic oe_ba_n);
    return !tst && !oe_ab_n && !oe_ba_n;
  endfunction

endpackage

// File: rtl/ubt_edge.sv
module ubt_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= '0;
    else        lvl_d <= lvl;
  end

  assign rise = lvl & ~lvl_d;
endmodule

// File: rtl/ubt_lane.sv
module ubt_lane #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= d;
  end
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
  parameter int unsigned HALF_W = ubt_pkg::DEF_HALF_W,
  parameter int unsigned NHALF  = ubt_pkg::DEF_NHALF,
  localparam int unsigned BUS_W = HALF_W * NHALF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_mode,
  input  logic             join18,
  input  logic [BUS_W-1:0] a_in,
  input  logic [BUS_W-1:0] b_in,
  input  logic [NHALF-1:0] ab_oe_n,
  input  logic [NHALF-1:0] ba_oe_n,
  input  logic [NHALF-1:0] ab_le,
  input  logic [NHALF-1:0] ba_le,
  input  logic [NHALF-1:0] ab_ck,
  input  logic [NHALF-1:0] ba_ck,
  input  logic [BUS_W-1:0] tst_a_val,
  input  logic [BUS_W-1:0] tst_a_en,
  input  logic [BUS_W-1:0] tst_b_val,
  input  logic [BUS_W-1:0] tst_b_en,
  output logic [BUS_W-1:0] a_out,
  output logic [BUS_W-1:0] a_oe,
  output logic [BUS_W-1:0] b_out,
  output logic [BUS_W-1:0] b_oe,
  output logic [NHALF-1:0] contention
);
  import ubt_pkg::*;

  // Named internal events for the checker.
  logic [NHALF-1:0] ab_rise_raw, ba_rise_raw;
  logic [NHALF-1:0] ab_rise, ba_rise;
  logic [NHALF-1:0] ab_le_e, ba_le_e, ab_oe_n_e, ba_oe_n_e;
  logic [NHALF-1:0] ab_upd, ba_upd;
  logic [BUS_W-1:0] ab_q, ba_q;
  logic [BUS_W-1:0] ab_view, ba_view;

  ubt_edge #(.N(NHALF)) u_ab_edge (.clk(clk), .rst_n(rst_n), .lvl(ab_ck), .rise(ab_rise_raw));
  ubt_edge #(.N(NHALF)) u_ba_edge (.clk(clk), .rst_n(rst_n), .lvl(ba_ck), .rise(ba_rise_raw));

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    localparam int unsigned LO = h * HALF_W;

    assign ab_le_e[h]   = ctl_pick(join18, ab_le[h],   ab_le[0]);
    assign ba_le_e[h]   = ctl_pick(join18, ba_le[h],   ba_le[0]);
    assign ab_oe_n_e[h] = ctl_pick(join18, ab_oe_n[h], ab_oe_n[0]);
    assign ba_oe_n_e[h] = ctl_pick(join18, ba_oe_n[h], ba_oe_n[0]);
    assign ab_rise[h]   = ctl_pick(join18, ab_rise_raw[h], ab_rise_raw[0]);
    assign ba_rise[h]   = ctl_pick(join18, ba_rise_raw[h], ba_rise_raw[0]);

    assign ab_upd[h] = store_now(test_mode, ab_le_e[h], ab_rise[h]);
    assign ba_upd[h] = store_now(test_mode, ba_le_e[h], ba_rise[h]);

    ubt_lane #(.W(HALF_W)) u_ab_lane (
      .clk(clk), .rst_n(rst_n), .upd(ab_upd[h]),
      .d(a_in[LO +: HALF_W]), .q(ab_q[LO +: HALF_W])
    );
    ubt_lane #(.W(HALF_W)) u_ba_lane (
      .clk(clk), .rst_n(rst_n), .upd(ba_upd[h]),
      .d(b_in[LO +: HALF_W]), .q(ba_q[LO +: HALF_W])
    );

    assign ab_view[LO +: HALF_W] = ab_le_e[h] ? a_in[LO +: HALF_W] : ab_q[LO +: HALF_W];
    assign ba_view[LO +: HALF_W] = ba_le_e[h] ? b_in[LO +: HALF_W] : ba_q[LO +: HALF_W];

    always_comb begin
      if (test_mode) begin
        b_out[LO +: HALF_W] = tst_b_val[LO +: HALF_W];
        b_oe [LO +: HALF_W] = tst_b_en [LO +: HALF_W];
        a_out[LO +: HALF_W] = tst_a_val[LO +: HALF_W];
        a_oe [LO +: HALF_W] = tst_a_en [LO +: HALF_W];
      end else begin
        b_out[LO +: HALF_W] = ab_oe_n_e[h] ? '0 : ab_view[LO +: HALF_W];
        b_oe [LO +: HALF_W] = {HALF_W{!ab_oe_n_e[h]}};
        a_out[LO +: HALF_W] = ba_oe_n_e[h] ? '0 : ba_view[LO +: HALF_W];
        a_oe [LO +: HALF_W] = {HALF_W{!ba_oe_n_e[h]}};
      end
    end

    assign contention[h] = clash(test_mode, ab_oe_n_e[h], ba_oe_n_e[h]);
  end
endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
  parameter int unsigned HALF_W = 9,
  parameter int unsigned NHALF  = 2,
  localparam int unsigned BUS_W = HALF_W * NHALF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             test_mode,
  input logic [BUS_W-1:0] a_in,
  input logic [BUS_W-1:0] tst_b_val,
  input logic [BUS_W-1:0] tst_b_en,
  input logic [BUS_W-1:0] b_out,
  input logic [BUS_W-1:0] b_oe,
  input logic [NHALF-1:0] contention,
  input logic [NHALF-1:0] ab_le_e,
  input logic [NHALF-1:0] ab_oe_n_e,
  input logic [NHALF-1:0] ba_oe_n_e,
  input logic [NHALF-1:0] ab_rise,
  input logic [BUS_W-1:0] ab_q
);
  for (genvar h = 0; h < NHALF; h++) begin : g_chk
    localparam int unsigned LO = h * HALF_W;

    p_transp_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode && ab_le_e[h] && !ab_oe_n_e[h]) |-> b_out[LO +: HALF_W] == a_in[LO +: HALF_W]);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode || (!ab_le_e[h] && !ab_rise[h])) |=> $stable(ab_q[LO +: HALF_W]));

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode && !ab_le_e[h] && ab_rise[h]) |=> ab_q[LO +: HALF_W] == $past(a_in[LO +: HALF_W]));

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode && ab_oe_n_e[h]) |-> (b_oe[LO +: HALF_W] == '0 && b_out[LO +: HALF_W] == '0));

    p_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
      contention[h] |-> (!test_mode && !ab_oe_n_e[h] && !ba_oe_n_e[h]));
  end

  p_handover_r8: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> (b_out == tst_b_val && b_oe == tst_b_en && contention == '0));
endmodule

bind ubt_xcvr ubt_xcvr_chk #(.HALF_W(HALF_W), .NHALF(NHALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .a_in(a_in),
  .tst_b_val(tst_b_val), .tst_b_en(tst_b_en), .b_out(b_out), .b_oe(b_oe),
  .contention(contention), .ab_le_e(ab_le_e), .ab_oe_n_e(ab_oe_n_e),
  .ba_oe_n_e(ba_oe_n_e), .ab_rise(ab_rise), .ab_q(ab_q)
);

// File: tb/ubt_xcvr_tb.sv
module ubt_xcvr_tb;
  localparam int W = 9;
  localparam int BW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_mode = 1'b0, join18 = 1'b0;
  logic [BW-1:0] a_in = '0, b_in = '0;
  logic [1:0] ab_oe_n = 2'b11, ba_oe_n = 2'b11, ab_le = '0, ba_le = '0, ab_ck = '0, ba_ck = '0;
  logic [BW-1:0] tst_a_val = '0, tst_a_en = '0, tst_b_val = '0, tst_b_en = '0;
  logic [BW-1:0] a_out, a_oe, b_out, b_oe;
  logic [1:0] contention;

  int n_run = 0, n_fail = 0;
  logic [BW-1:0] m_ab = '0, m_ba = '0;
  logic [1:0] p_ab = '0, p_ba = '0;
  int dummy;

  always #4 clk = ~clk;

  ubt_xcvr u_dut (.*);

  task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic eff(input logic [1:0] v, input int h);
    return join18 ? v[0] : v[h];
  endfunction

  // Model state update for the system clock edge just passed.
  task automatic model_edge();
    for (int h = 0; h < 2; h++) begin
      logic rab, rba;
      rab = eff(ab_ck, h) && !eff(p_ab, h);
      rba = eff(ba_ck, h) && !eff(p_ba, h);
      if (!test_mode && (eff(ab_le, h) || rab)) m_ab[h*W +: W] = a_in[h*W +: W];
      if (!test_mode && (eff(ba_le, h) || rba)) m_ba[h*W +: W] = b_in[h*W +: W];
    end
    p_ab = ab_ck;
    p_ba = ba_ck;
  endtask

  task automatic check_all();
    for (int h = 0; h < 2; h++) begin
      logic [W-1:0] eb, ea, eob, eoa;
      string tg;
      if (test_mode) begin
        eb = tst_b_val[h*W +: W]; eob = tst_b_en[h*W +: W];
        ea = tst_a_val[h*W +: W]; eoa = tst_a_en[h*W +: W];
        tg = "R8";
      end else begin
        eb  = eff(ab_oe_n, h) ? '0 : (eff(ab_le, h) ? a_in[h*W +: W] : m_ab[h*W +: W]);
        eob = {W{!eff(ab_oe_n, h)}};
        ea  = eff(ba_oe_n, h) ? '0 : (eff(ba_le, h) ? b_in[h*W +: W] : m_ba[h*W +: W]);
        eoa = {W{!eff(ba_oe_n, h)}};
        tg  = (join18 && h == 1) ? "R7" : (eff(ab_le, h) ? "R1" : "R2/R3");
      end
      chk(tg, BW'(b_out[h*W +: W]), BW'(eb));
      chk("R4", BW'(b_oe[h*W +: W]), BW'(eob));
      chk(test_mode ? "R8" : "R5", BW'(a_out[h*W +: W]), BW'(ea));
      chk("R5", BW'(a_oe[h*W +: W]), BW'(eoa));
      chk("R9", BW'(contention[h]),
          BW'(!test_mode && !eff(ab_oe_n, h) && !eff(ba_oe_n, h)));
    end
  endtask

  // One cycle: let a posedge pass, update the model, check, at negedge.
  task automatic step();
    @(negedge clk);
    model_edge();
    check_all();
  endtask

  initial begin
    dummy = $urandom(32'd20240611);
    repeat (2) @(negedge clk);
    // R10: reset clears stored words, outputs in latched mode show 0.
    ab_oe_n = 2'b00; ba_oe_n = 2'b00; a_in = '1; b_in = '1;
    #1;
    chk("R10", b_out, '0);
    chk("R10", a_out, '0);
    @(negedge clk); rst_n = 1'b1;
    ba_oe_n = 2'b11;
    step();
    chk("R10", b_out, '0);

    // R3: a rising direction clock stores, a held-high clock does not.
    a_in = 18'h2A5A5; ab_ck = 2'b11; step();
    chk("R3", b_out, 18'h2A5A5);
    a_in = 18'h15A5A; step();
    chk("R3", b_out, 18'h2A5A5);

    // R1 then R2: transparent, then hold after latch enable falls.
    ab_le = 2'b11; a_in = 18'h0F0F0; #1;
    chk("R1", b_out, 18'h0F0F0);
    step();
    ab_le = 2'b00; a_in = 18'h3FFFF; step();
    chk("R2", b_out, 18'h0F0F0);

    // R6: half 0 transparent, half 1 latched.
    ab_le = 2'b01; a_in = 18'h00155; step();
    chk("R6", b_out, {9'h078, 9'h155});

    // R7: joined, index-1 controls ignored.
    join18 = 1'b1; ab_le = 2'b10; ab_oe_n = 2'b10; a_in = 18'h12345; step();
    chk("R7", b_out, {9'h078, 9'h155});
    chk("R7", b_oe, '1);

    // R8: test mode freezes storage.
    join18 = 1'b0; test_mode = 1'b1; ab_le = 2'b11; a_in = 18'h0AAAA;
    tst_b_val = 18'h1C3C3; tst_b_en = 18'h00FFF; step();
    chk("R8", b_out, 18'h1C3C3);
    test_mode = 1'b0; ab_le = 2'b00; ab_oe_n = 2'b00; step();
    chk("R8", b_out, {9'h078, 9'h155});

    // Random phase.
    for (int i = 0; i < 3000; i++) begin
      a_in = BW'($urandom); b_in = BW'($urandom);
      ab_le = 2'($urandom_range(0,3) == 0 ? $urandom : 0);
      ba_le = 2'($urandom_range(0,3) == 0 ? $urandom : 0);
      ab_ck = 2'($urandom); ba_ck = 2'($urandom);
      ab_oe_n = 2'($urandom); ba_oe_n = 2'($urandom);
      test_mode = ($urandom_range(0,7) == 0);
      join18 = ($urandom_range(0,3) == 0);
      tst_a_val = BW'($urandom); tst_a_en = BW'($urandom);
      tst_b_val = BW'($urandom); tst_b_en = BW'($urandom);
      step();
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule